// File: doc/BRIEF.md
# Pulse-Width Modulation Timer with Staged Reload

This block is a counter clocked by the system clock. It drives a rectangular waveform. Software programs the period and the high-time through a small register port. The output's assertion level can be chosen, and a latched interrupt flags the end of every period.

New period and width values are written into shadow copies first. Writing the width shadow arms an update. The armed pair then moves into the running counter together, at the next reload. A reload is either the end of a period or the start of the timer. Because of this, a running waveform never mixes an old period with a new width.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset, the control, period, width and status reads all return 0, `irq` is 0 and `pwm_out` is 1, which is the deasserted level for the reset polarity.
- R2: Cycle 0 is the first cycle after the edge that takes the enable. With period P and width W valid, the output in cycle n is asserted exactly when n mod P < W.
- R3: Control bit 1 selects the assertion level. When it is 1, asserted means a high output. When it is 0, asserted means a low output.
- R4: The interrupt latch is set only when control bit 2 is 1. When set, it appears in cycle P after the start and at every period end after that. With bit 2 at 0, `irq` stays 0.
- R5: Writing address 3 with data bit 0 at 1 clears the latch. If a clear and a period end fall in the same cycle, the latch ends up set.
- R6: A write to the period (address 1) alone leaves the running waveform unchanged. A write to the width (address 2) arms the update. Status bit 1 reads 1 while an update is armed.
- R7: An armed pair takes effect only at the next reload. The current period always finishes first.
- R8: With control bit 0 at 0, the output sits at its deasserted level and the counter is cleared. Any armed pair is applied when the timer is next enabled.
- R9: A period below 2, a width of 0, or a width not smaller than the period holds the output deasserted. The counter keeps reloading in that state. A period below 2 reloads every cycle, so a later armed update still gets applied.
- R10: Reading address 1 or 2 returns the staged values. Address 0 reads back {interrupt enable, polarity, enable} in bits 2:0. Status reads {pending, latch} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 period, 2 width, 3 status |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Read data |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt latch |

## Verification
The bench sweeps every period from 2 to 6 against every width from 0 up to the period, under both polarities. The invalid widths in that sweep would expose a design that lets the output toggle or stick asserted. A design that swaps the new values in mid-period fails the timed test: there, a period write and a width write land in the middle of a period, and the old pattern must still complete. The bench also disables and re-enables with only the period written, which catches a design that arms on period writes. A clear issued in the same cycle as a period end catches a latch where the clear wins. A zero period followed by a valid update catches a counter that hangs rather than reloading.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_WIDTH  = 2'd2,
        REG_STATUS = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              period_end,
    input  logic              load_take,
    output logic [CNT_W-1:0]  rd_data,
    output logic              en,
    output logic              pol,
    output logic [CNT_W-1:0]  stg_period,
    output logic [CNT_W-1:0]  stg_width,
    output logic              armed,
    output logic              irq
);
    typedef struct packed {
        logic             en;
        logic             pol;
        logic             irq_en;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
        logic             armed;
        logic             irq;
    } cfg_t;

    cfg_t s_d, s_q;
    logic width_wr;

    always_comb begin
        s_d      = s_q;
        width_wr = wr_en && (reg_addr_e'(wr_addr) == REG_WIDTH);
        if (load_take) s_d.armed = 1'b0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL: begin
                    s_d.en     = wr_data[0];
                    s_d.pol    = wr_data[1];
                    s_d.irq_en = wr_data[2];
                end
                REG_PERIOD: s_d.period = wr_data;
                REG_WIDTH: begin
                    s_d.width = wr_data;
                    s_d.armed = 1'b1;
                end
                REG_STATUS: if (wr_data[0]) s_d.irq = 1'b0;
                default: ;
            endcase
        end
        if (period_end && s_q.irq_en) s_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            REG_CTRL:   rd_data[2:0] = {s_q.irq_en, s_q.pol, s_q.en};
            REG_PERIOD: rd_data = s_q.period;
            REG_WIDTH:  rd_data = s_q.width;
            REG_STATUS: rd_data[1:0] = {s_q.armed, s_q.irq};
            default: ;
        endcase
    end

    assign en         = s_q.en;
    assign pol        = s_q.pol;
    assign stg_period = s_q.period;
    assign stg_width  = s_q.width;
    assign armed      = s_q.armed;
    assign irq        = s_q.irq;

    AST_WIDTH_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        width_wr |=> armed); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && s_q.irq_en) |=> irq); // R5
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic             armed,
    input  logic [CNT_W-1:0] stg_period,
    input  logic [CNT_W-1:0] stg_width,
    output logic             load_take,
    output logic             period_end,
    output logic             pwm_out
);
    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
    } core_t;

    core_t s_d, s_q;
    logic [CNT_W:0] cnt_inc;
    logic           start, reload, valid, asserted;

    always_comb begin
        s_d        = s_q;
        cnt_inc    = {1'b0, s_q.cnt} + 1'b1;
        period_end = en && s_q.running && (cnt_inc >= {1'b0, s_q.period});
        start      = en && !s_q.running;
        reload     = start || period_end;
        load_take  = reload && armed;
        if (!en) begin
            s_d.running = 1'b0;
            s_d.cnt     = '0;
        end else begin
            s_d.running = 1'b1;
            s_d.cnt     = reload ? '0 : cnt_inc[CNT_W-1:0];
            if (load_take) begin
                s_d.period = stg_period;
                s_d.width  = stg_width;
            end
        end
        valid    = (s_q.period >= CNT_W'(2)) && (s_q.width != '0)
                   && (s_q.width < s_q.period);
        asserted = en && s_q.running && valid && (s_q.cnt < s_q.width);
        pwm_out  = pol ? asserted : !asserted;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.running |-> (s_q.cnt == '0 || s_q.cnt < s_q.period)); // R9
    AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (s_q.cnt == '0)); // R2
    AST_LOAD_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.period != $past(s_q.period)) |-> $past(load_take)); // R7
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.cnt == '0 && !s_q.running)); // R8
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pwm_out,
    output logic              irq
);
    logic             en, pol, armed, load_take, period_end;
    logic [CNT_W-1:0] stg_period, stg_width;

    pwm_cfg_regs #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .period_end(period_end),
        .load_take(load_take), .rd_data(rd_data), .en(en), .pol(pol),
        .stg_period(stg_period), .stg_width(stg_width), .armed(armed),
        .irq(irq)
    );

    pwm_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .armed(armed),
        .stg_period(stg_period), .stg_width(stg_width),
        .load_take(load_take), .period_end(period_end), .pwm_out(pwm_out)
    );
endmodule

// File: tb/test_pwm_timer_top.sv
`timescale 1ns/1ps
module test_pwm_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [31:0] rd_data;
    logic        pwm_out, irq;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_timer_top #(.CNT_W(32)) i_pwm_timer_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic pin(input bit act, input bit p);
        return p ? act : !act;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwm_out", {31'd0, pwm_out}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #0.1;
            chk("R1 readback", rd_data, 32'd0);
        end
        rd_addr = 2'd3;

        // R2 R3 R4 R9 sweep
        for (int p = 0; p < 2; p++)
            for (int per = 2; per <= 6; per++)
                for (int w = 0; w <= per; w++) begin
                    wr(2'd0, 32'(p << 1));
                    wr(2'd3, 32'd1);
                    wr(2'd1, 32'(per));
                    wr(2'd2, 32'(w));
                    #0.1;
                    chk("R6 pending", {31'd0, rd_data[1]}, 32'd1);
                    chk("R8 idle level", {31'd0, pwm_out}, {31'd0, pin(1'b0, p[0])});
                    rd_addr = 2'd1; #0.1;
                    chk("R10 period readback", rd_data, 32'(per));
                    rd_addr = 2'd0; #0.1;
                    chk("R10 ctrl readback", rd_data, 32'(p << 1));
                    rd_addr = 2'd3;
                    wr(2'd0, 32'(5 | (p << 1)));
                    for (int n = 0; n < 3 * per; n++) begin
                        @(negedge clk);
                        chk("R2 R3 R9 pattern", {31'd0, pwm_out},
                            {31'd0, pin((w != 0) && (w < per) && ((n % per) < w), p[0])});
                        chk("R4 irq", {31'd0, irq}, {31'd0, n >= per});
                    end
                    chk("R7 pending cleared", {31'd0, rd_data[1]}, 32'd0);
                end

        // R7 mid-period update, R4 with irq disabled
        wr(2'd0, 32'd2);
        wr(2'd3, 32'd1);
        wr(2'd1, 32'd8);
        wr(2'd2, 32'd4);
        wr(2'd0, 32'd3);
        for (int n = 0; n < 21; n++) begin
            @(negedge clk);
            chk("R7 mid-period", {31'd0, pwm_out},
                {31'd0, (n < 8) ? ((n % 8) < 4) : (((n - 8) % 5) < 2)});
            chk("R4 irq off", {31'd0, irq}, 32'd0);
            if (n >= 3) chk("R6 pending", {31'd0, rd_data[1]}, {31'd0, n < 8});
            if (n == 1) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd5; end
            if (n == 2) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd2; end
            if (n == 3) wr_en = 1'b0;
        end

        // R6 R8: period-only write not applied across re-enable
        wr(2'd0, 32'd2); wr(2'd1, 32'd4); wr(2'd2, 32'd1); wr(2'd0, 32'd3);
        wr(2'd1, 32'd6); wr(2'd0, 32'd2);
        chk("R8 disabled level", {31'd0, pwm_out}, 32'd0);
        wr(2'd0, 32'd3);
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            chk("R6 period alone", {31'd0, pwm_out}, {31'd0, (n % 4) < 1});
        end
        wr(2'd0, 32'd2); wr(2'd2, 32'd3); wr(2'd0, 32'd3);
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            chk("R8 applied at enable", {31'd0, pwm_out}, {31'd0, (n % 6) < 3});
        end

        // R9 zero period keeps reloading
        wr(2'd0, 32'd2); wr(2'd1, 32'd0); wr(2'd2, 32'd0); wr(2'd0, 32'd3);
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            chk("R9 invalid held", {31'd0, pwm_out}, 32'd0);
        end
        wr(2'd1, 32'd3);
        chk("R9 period pending", {31'd0, pwm_out}, 32'd0);
        wr(2'd2, 32'd1);
        for (int n = 0; n < 9; n++) begin
            @(negedge clk);
            chk("R9 recovers", {31'd0, pwm_out}, {31'd0, (n % 3) < 1});
        end

        // R5 clear versus period end
        wr(2'd0, 32'd2); wr(2'd3, 32'd1); wr(2'd1, 32'd2); wr(2'd2, 32'd1);
        wr(2'd0, 32'd7);
        for (int n = 0; n < 7; n++) begin
            @(negedge clk);
            chk("R5 latch", {31'd0, irq}, {31'd0, !(n < 2 || n == 5)});
            chk("R2 fastest toggle", {31'd0, pwm_out}, {31'd0, (n % 2) == 0});
            if (n == 3 || n == 4) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'd1; end
            if (n == 5) wr_en = 1'b0;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule